// File: doc/BRIEF.md
# Stack-Based Call/Return Sequencer

This block owns the program counter and the stack pointer of a small processor core and decides, once per accepted operation, where control goes next. Four operations are offered: step to the following address, branch to an effective address (taken only when a qualifier says so), call a subroutine, and return from one. Return addresses live in a memory stack that grows downward, so calls may nest as deep as the stack region allows.

Calls and returns share one synchronous memory port, which the block drives with registered address, write data, write enable and read enable signals. A call pre-decrements the stack pointer and then stores the return address while jumping. A return reads the top entry, then loads it into the program counter and post-increments the stack pointer. While such a sequence runs, a busy output is high and further operations are ignored. A call on a full stack or a return on an empty stack is refused and sets a sticky error flag.

Top module: `pc_sequencer`

## Requirements
- R1: After reset the PC is 0, SP equals STACK_TOP, and busy, mem_we, mem_re, ovf_err and udf_err are all 0.
- R2: An accepted step operation (op = 2'b00) raises the PC by one on the next clock edge, wrapping from all ones to zero.
- R3: An accepted branch (op = 2'b01) loads the PC with ea on the next edge when take is 1, and raises the PC by one when take is 0.
- R4: An accepted call (op = 2'b10) lowers SP by one and raises busy one edge later; on the following edge the PC becomes ea, busy falls, and mem_we is high for one cycle with mem_addr equal to the lowered SP and mem_wdata equal to the call's PC plus one.
- R5: An accepted return (op = 2'b11) drives mem_re high with mem_addr equal to SP one edge later; two edges after that the PC holds the word read from that address, SP is one higher, and busy falls.
- R6: Any operation presented while busy is 1 is ignored.
- R7: A call when SP equals STACK_TOP minus STACK_DEPTH sets ovf_err, which stays set until reset, and leaves PC, SP and the memory port unchanged; SP never leaves the range from that floor to STACK_TOP.
- R8: A return when SP equals STACK_TOP sets udf_err, which stays set until reset, and leaves PC, SP and the memory port unchanged.
- R9: Nested calls return in last-in first-out order to the address following each call.
- R10: With op_valid low and busy low, PC and SP hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op | input | 2 | 00 step, 01 branch, 10 call, 11 return |
| ea | input | ADDR_W | Effective (target) address |
| take | input | 1 | Branch qualifier for op 01 |
| mem_rdata | input | ADDR_W | Read data from stack memory, one cycle after mem_re |
| pc | output | ADDR_W | Program counter |
| sp | output | ADDR_W | Stack pointer (address of the top entry) |
| busy | output | 1 | Call or return sequence in progress |
| mem_addr | output | ADDR_W | Stack memory address |
| mem_wdata | output | ADDR_W | Stack memory write data |
| mem_we | output | 1 | Stack memory write enable |
| mem_re | output | 1 | Stack memory read enable |
| ovf_err | output | 1 | Sticky stack-overflow flag |
| udf_err | output | 1 | Sticky stack-underflow flag |

## Verification
The bench builds the block with ADDR_W = 8, STACK_TOP = 8'hF4 and STACK_DEPTH = 4. The narrow address width lets a single branch to 8'hFF followed by a step reach the PC wrap, and the four-entry stack lets a handful of calls fill it so that the overflow refusal, the underflow refusal and a full four-deep last-in first-out unwind are all reached in a short run.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    OP_NEXT   = 2'b00,
    OP_BRANCH = 2'b01,
    OP_CALL   = 2'b10,
    OP_RETURN = 2'b11
  } seq_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PUSH,
    ST_POP_WAIT,
    ST_POP_LOAD
  } seq_state_e;
endpackage

// File: rtl/seq_sp_unit.sv
module seq_sp_unit #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] TOP = '1,
  parameter logic [ADDR_W-1:0] FLOOR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec,
  input  logic              inc,
  output logic [ADDR_W-1:0] sp,
  output logic              at_floor,
  output logic              at_top
);
  always_ff @(posedge clk) begin
    if (rst)      sp <= TOP;
    else if (dec) sp <= sp - 1'b1;
    else if (inc) sp <= sp + 1'b1;
  end

  assign at_floor = (sp == FLOOR);
  assign at_top   = (sp == TOP);
endmodule

// File: rtl/seq_pc_unit.sv
module seq_pc_unit #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              adv,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] pc_inc
);
  assign pc_inc = pc + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)      pc <= '0;
    else if (ld)  pc <= ld_val;
    else if (adv) pc <= pc_inc;
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] STACK_TOP = '1,
  parameter int STACK_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [1:0]        op,
  input  logic [ADDR_W-1:0] ea,
  input  logic              take,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] sp,
  output logic              busy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic              ovf_err,
  output logic              udf_err
);
  import seq_pkg::*;

  localparam logic [ADDR_W-1:0] STACK_FLOOR = STACK_TOP - ADDR_W'(STACK_DEPTH);

  seq_state_e        state, state_nxt;
  seq_op_e           op_e;
  logic [ADDR_W-1:0] target_q;
  logic              cap_target;
  logic              pc_ld, pc_adv;
  logic [ADDR_W-1:0] pc_ld_val, pc_inc;
  logic              sp_dec, sp_inc, sp_at_floor, sp_at_top;
  logic              wr_issue, rd_issue, set_ovf, set_udf;

  assign op_e = seq_op_e'(op);

  seq_pc_unit #(.ADDR_W(ADDR_W)) u_pc (
    .clk(clk), .rst(rst), .ld(pc_ld), .ld_val(pc_ld_val),
    .adv(pc_adv), .pc(pc), .pc_inc(pc_inc)
  );

  seq_sp_unit #(.ADDR_W(ADDR_W), .TOP(STACK_TOP), .FLOOR(STACK_FLOOR)) u_sp (
    .clk(clk), .rst(rst), .dec(sp_dec), .inc(sp_inc),
    .sp(sp), .at_floor(sp_at_floor), .at_top(sp_at_top)
  );

  always_comb begin
    state_nxt  = state;
    pc_ld      = 1'b0;
    pc_ld_val  = ea;
    pc_adv     = 1'b0;
    sp_dec     = 1'b0;
    sp_inc     = 1'b0;
    wr_issue   = 1'b0;
    rd_issue   = 1'b0;
    set_ovf    = 1'b0;
    set_udf    = 1'b0;
    cap_target = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (op_valid) begin
          unique case (op_e)
            OP_NEXT:   pc_adv = 1'b1;
            OP_BRANCH: begin
              pc_ld  = take;
              pc_adv = !take;
            end
            OP_CALL: begin
              if (sp_at_floor) set_ovf = 1'b1;
              else begin
                sp_dec     = 1'b1;
                cap_target = 1'b1;
                state_nxt  = ST_PUSH;
              end
            end
            OP_RETURN: begin
              if (sp_at_top) set_udf = 1'b1;
              else begin
                rd_issue  = 1'b1;
                state_nxt = ST_POP_WAIT;
              end
            end
          endcase
        end
      end
      ST_PUSH: begin
        wr_issue  = 1'b1;
        pc_ld     = 1'b1;
        pc_ld_val = target_q;
        state_nxt = ST_IDLE;
      end
      ST_POP_WAIT: state_nxt = ST_POP_LOAD;
      ST_POP_LOAD: begin
        pc_ld     = 1'b1;
        pc_ld_val = mem_rdata;
        sp_inc    = 1'b1;
        state_nxt = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      target_q  <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      ovf_err   <= 1'b0;
      udf_err   <= 1'b0;
    end else begin
      state  <= state_nxt;
      busy   <= (state_nxt != ST_IDLE);
      mem_we <= wr_issue;
      mem_re <= rd_issue;
      if (cap_target) target_q <= ea;
      if (wr_issue) begin
        mem_addr  <= sp;
        mem_wdata <= pc_inc;
      end else if (rd_issue) begin
        mem_addr  <= sp;
      end
      if (set_ovf) ovf_err <= 1'b1;
      if (set_udf) udf_err <= 1'b1;
    end
  end
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] STACK_TOP = '1,
  parameter int STACK_DEPTH = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [1:0]        op,
  input logic [ADDR_W-1:0] ea,
  input logic              take,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] sp,
  input logic              busy,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              mem_re,
  input logic              ovf_err,
  input logic              udf_err
);
  localparam logic [ADDR_W-1:0] FLOOR = STACK_TOP - ADDR_W'(STACK_DEPTH);

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && op_valid && op == 2'b00) |=> (pc == ADDR_W'($past(pc) + 1'b1)));

  assert_branch_taken_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy && op_valid && op == 2'b01 && take) |=> (pc == $past(ea)));

  assert_push_addr_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr == sp));

  assert_read_busy_R5: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> (busy && mem_addr == sp && !mem_we));

  assert_sp_range_R7: assert property (@(posedge clk) disable iff (rst)
    (sp >= FLOOR) && (sp <= STACK_TOP));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err);

  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    udf_err |=> udf_err);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !op_valid) |=> ($stable(pc) && $stable(sp)));
endmodule

bind pc_sequencer seq_checker #(
  .ADDR_W(ADDR_W), .STACK_TOP(STACK_TOP), .STACK_DEPTH(STACK_DEPTH)
) u_seq_checker (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op(op), .ea(ea), .take(take),
  .pc(pc), .sp(sp), .busy(busy), .mem_addr(mem_addr), .mem_we(mem_we),
  .mem_re(mem_re), .ovf_err(ovf_err), .udf_err(udf_err)
);

// File: tb/tb_pc_sequencer.sv
`timescale 1ns/1ps
module tb_pc_sequencer;
  localparam int AW = 8;
  localparam logic [AW-1:0] TOP = 8'hF4;
  localparam int DEPTH = 4;
  localparam logic [AW-1:0] FLOOR = TOP - AW'(DEPTH);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 1'b0;
  logic [1:0]    op = 2'b00;
  logic [AW-1:0] ea = '0;
  logic          take = 1'b0;
  logic [AW-1:0] mem_rdata;
  logic [AW-1:0] pc, sp, mem_addr, mem_wdata;
  logic          busy, mem_we, mem_re, ovf_err, udf_err;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pc_sequencer #(.ADDR_W(AW), .STACK_TOP(TOP), .STACK_DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op(op), .ea(ea), .take(take),
    .mem_rdata(mem_rdata), .pc(pc), .sp(sp), .busy(busy),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .ovf_err(ovf_err), .udf_err(udf_err)
  );

  logic [AW-1:0] stack_mem [2**AW];
  always_ff @(posedge clk) begin
    if (mem_we) stack_mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= stack_mem[mem_addr];
  end

  typedef struct {
    logic [AW-1:0] pc;
    logic [AW-1:0] sp;
    logic          ovf;
    logic          udf;
    string         tag;
  } exp_t;

  exp_t sb_q[$];
  event chk_ev;

  logic [AW-1:0] m_pc, m_sp;
  logic          m_ovf, m_udf;
  logic [AW-1:0] m_stack[$];

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin : monitor
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " pc"}, pc, e.pc);
        check({e.tag, " sp"}, sp, e.sp);
        check({e.tag, " ovf_err"}, ovf_err, e.ovf);
        check({e.tag, " udf_err"}, udf_err, e.udf);
      end
    end
  end

  task automatic expect_state(string tag);
    exp_t e;
    e.pc = m_pc; e.sp = m_sp; e.ovf = m_ovf; e.udf = m_udf; e.tag = tag;
    sb_q.push_back(e);
    -> chk_ev;
    #0;
  endtask

  task automatic issue(logic [1:0] o, logic [AW-1:0] a, logic t);
    op_valid = 1'b1; op = o; ea = a; take = t;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic do_next(string tag);
    issue(2'b00, 8'h00, 1'b0);
    m_pc = m_pc + 1'b1;
    expect_state(tag);
  endtask

  task automatic do_branch(logic [AW-1:0] a, logic t, string tag);
    issue(2'b01, a, t);
    m_pc = t ? a : AW'(m_pc + 1'b1);
    expect_state(tag);
  endtask

  task automatic do_call(logic [AW-1:0] a, bit poke_busy, string tag);
    if (m_sp == FLOOR) begin
      issue(2'b10, a, 1'b0);
      m_ovf = 1'b1;
      check("R7 no write on overflow", mem_we, 0);
      check("R7 not busy on overflow", busy, 0);
      expect_state(tag);
    end else begin
      logic [AW-1:0] ret;
      ret = m_pc + 1'b1;
      issue(2'b10, a, 1'b0);
      check("R4 busy after call", busy, 1);
      check("R4 sp lowered", sp, m_sp - 1'b1);
      check("R4 no write yet", mem_we, 0);
      if (poke_busy) begin
        op_valid = 1'b1; op = 2'b00;
      end
      @(negedge clk);
      op_valid = 1'b0;
      check("R4 write enable", mem_we, 1);
      check("R4 write addr", mem_addr, m_sp - 1'b1);
      check("R4 return addr", mem_wdata, ret);
      check("R4 busy low", busy, 0);
      m_sp = m_sp - 1'b1;
      m_stack.push_back(ret);
      m_pc = a;
      expect_state(tag);
    end
  endtask

  task automatic do_return(string tag);
    if (m_sp == TOP) begin
      issue(2'b11, 8'h00, 1'b0);
      m_udf = 1'b1;
      check("R8 no read on underflow", mem_re, 0);
      check("R8 not busy on underflow", busy, 0);
      expect_state(tag);
    end else begin
      issue(2'b11, 8'h00, 1'b0);
      check("R5 read enable", mem_re, 1);
      check("R5 read addr", mem_addr, m_sp);
      check("R5 busy", busy, 1);
      @(negedge clk);
      check("R5 still busy", busy, 1);
      check("R5 pc not yet loaded", pc, m_pc);
      @(negedge clk);
      check("R5 busy low", busy, 0);
      m_pc = m_stack.pop_back();
      m_sp = m_sp + 1'b1;
      expect_state(tag);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    m_pc = '0; m_sp = TOP; m_ovf = 1'b0; m_udf = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 mem_we", mem_we, 0);
    check("R1 mem_re", mem_re, 0);
    expect_state("R1 reset");

    do_next("R2 step 1");
    do_next("R2 step 2");
    do_branch(8'h40, 1'b1, "R3 taken");
    do_branch(8'h10, 1'b0, "R3 not taken");

    repeat (3) @(negedge clk);
    expect_state("R10 idle hold");

    do_call(8'h80, 1'b0, "R4 call");
    do_call(8'h90, 1'b1, "R6 op ignored while busy");
    do_next("R2 step in callee");
    do_return("R5 return inner");
    do_return("R5 return outer");
    do_return("R8 underflow");

    for (int i = 0; i < DEPTH; i++) do_call(AW'(8'h20 + i * 8'h10), 1'b0, "R9 nest call");
    do_call(8'hAA, 1'b0, "R7 overflow");
    for (int i = 0; i < DEPTH; i++) do_return("R9 LIFO return");
    do_return("R8 underflow sticky");

    do_branch(8'hFF, 1'b1, "R3 to top");
    do_next("R2 wrap");

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule